// File: doc/BRIEF.md
# Thermostat Alarm with Fault Queue

This block drives an over-temperature alarm from a stream of converted temperature samples. Each sample is a 9-bit two's complement value in half-degree steps. It arrives with a one-cycle valid strobe and is compared against an upper trip threshold and a lower release threshold. Both thresholds are held in 16-bit registers whose top nine bits carry the temperature. A fault queue requires a programmable number of consecutive qualifying samples before the alarm changes state.

Two modes are available. In comparator mode the alarm behaves as a thermostat: it rises after enough hot samples and falls after enough cold ones. In interrupt mode the alarm latches when an event is detected and is released only by a register-read pulse or by entry into shutdown. Each release flips which event is watched next, so the watched event alternates between the upper threshold and the lower threshold. The polarity field selects how the alarm appears on the output pin.

Top module: `thermo_alarm`

## Requirements
- R1: The 2-bit queue field `cfg_queue` (bit 1 is the high-order bit) selects how many consecutive qualifying samples are needed: 0 needs 1, 1 needs 2, 2 needs 4 and 3 needs 6.
- R2: In comparator mode, with the alarm inactive, the alarm becomes active after the required number of consecutive valid samples strictly above the upper threshold. The change is visible on the pin in the cycle after the strobe of the last such sample.
- R3: In comparator mode, with the alarm active, the alarm becomes inactive after the required number of consecutive valid samples strictly below the lower threshold.
- R4: A valid sample that does not meet the watched condition restarts the consecutive count. A sample equal to a threshold is neither above it nor below it.
- R5: In interrupt mode (`cfg_intr`=1) the first assertion follows the required number of consecutive samples above the upper threshold. Once asserted, the alarm stays active whatever samples follow.
- R6: In interrupt mode an active alarm is cleared by a `reg_rd` pulse or by a 0-to-1 change of `cfg_sleep`. Each clear flips the watched event: after a clear from a high event, the next assertion needs consecutive samples below the lower threshold, and after a clear from a low event it again needs samples above the upper one.
- R7: In comparator mode, entering shutdown leaves the alarm unchanged. Samples that arrive while `cfg_sleep` is high are still evaluated in both modes, because the conversion in progress completes.
- R8: With `cfg_pol`=0 the pin is low when the alarm is active and high otherwise; with `cfg_pol`=1 the pin is high when the alarm is active. After reset the alarm is inactive and the high event is watched.
- R9: Each threshold is taken from bits 15 down to 7 of its register as a signed 9-bit value, and bits 6 down to 0 have no effect.
- R10: Sample data presented while `smp_vld` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_temp | input | 9 | Sample, signed, 0.5 degree per LSB |
| thr_hi | input | 16 | Upper trip threshold register |
| thr_lo | input | 16 | Lower release threshold register |
| cfg_queue | input | 2 | Fault queue code |
| cfg_pol | input | 1 | Pin polarity, 1 = active-high |
| cfg_intr | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| cfg_sleep | input | 1 | Shutdown request |
| reg_rd | input | 1 | Pulse for any register read |
| alarm_pin | output | 1 | Alarm level as presented on the pin |

## Verification
The bench uses the default parameters: a 9-bit sample, 16-bit threshold registers and a 3-bit fault counter. These values cover the full queue range up to six samples. They also place the threshold field at bits 15 to 7, so the ignored low bits can be made nonzero and negative thresholds can be reached. A behavioural model predicts the pin on every cycle. The bench walks each queue code, runs streams broken by equal-to-threshold samples, and steps the interrupt mode through several clear-and-rearm rounds using both kinds of clear.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

   localparam int QCODE_W = 2;

   typedef enum logic {
      WATCH_HIGH = 1'b0,
      WATCH_LOW  = 1'b1
   } watch_e;

   // Number of consecutive qualifying samples needed for a queue code.
   function automatic int unsigned fault_need(input logic [QCODE_W-1:0] code);
      int unsigned n;
      case (code)
         2'd0:    n = 1;
         2'd1:    n = 2;
         2'd2:    n = 4;
         default: n = 6;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/thermo_cmp.sv
module thermo_cmp #(
   parameter int TEMP_W = 9,
   parameter int REG_W  = 16
) (
   input  logic [TEMP_W-1:0] smp,
   input  logic [REG_W-1:0]  hi_reg,
   input  logic [REG_W-1:0]  lo_reg,
   output logic              above_hi,
   output logic              below_lo
);

   initial begin
      assert (REG_W >= TEMP_W) else $fatal(1, "threshold register narrower than sample");
      assert (TEMP_W >= 2) else $fatal(1, "sample too narrow");
   end

   logic signed [TEMP_W-1:0] hi_s;
   logic signed [TEMP_W-1:0] lo_s;

   generate
      if (REG_W == TEMP_W) begin : g_full
         assign hi_s = $signed(hi_reg);
         assign lo_s = $signed(lo_reg);
      end else begin : g_slice
         assign hi_s = $signed(hi_reg[REG_W-1 -: TEMP_W]);
         assign lo_s = $signed(lo_reg[REG_W-1 -: TEMP_W]);
      end
   endgenerate

   assign above_hi = $signed(smp) > hi_s;
   assign below_lo = $signed(smp) < lo_s;

endmodule

// File: rtl/thermo_fq.sv
module thermo_fq #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             hit,
   input  logic             hold,
   input  logic [CNT_W-1:0] need,
   output logic             fire
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
   assign fire    = step && hit && !hold && (cnt_inc >= {1'b0, need});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (hold) begin
         cnt <= '0;
      end else if (step) begin
         if (!hit || fire) cnt <= '0;
         else              cnt <= cnt_inc[CNT_W-1:0];
      end
   end

   // R4: a failing sample restarts the run
   assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hit) |=> (cnt == '0));

   // R2: a completed run starts the next one from zero
   assert_fire_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == '0));

endmodule

// File: rtl/thermo_state.sv
module thermo_state
   import thermo_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   intr,
   input  logic   sleep,
   input  logic   rd,
   input  logic   fire,
   output logic   alarm,
   output logic   hold,
   output watch_e watch
);

   logic arm_hi;
   logic sleep_q;
   logic clr;

   assign hold  = intr && alarm;
   assign clr   = hold && (rd || (sleep && !sleep_q));
   assign watch = intr ? (arm_hi ? WATCH_HIGH : WATCH_LOW)
                       : (alarm  ? WATCH_LOW  : WATCH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm   <= 1'b0;
         arm_hi  <= 1'b1;
         sleep_q <= 1'b0;
      end else begin
         sleep_q <= sleep;
         if (clr) begin
            alarm  <= 1'b0;
            arm_hi <= !arm_hi;
         end else if (fire) begin
            alarm  <= intr ? 1'b1 : !alarm;
         end
      end
   end

   // R2: the alarm only rises on a completed fault run
   assert_rise_needs_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm) |-> $past(fire));

   // R5: a latched interrupt only falls after a read or shutdown entry
   assert_intr_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (intr && $past(intr) && $fell(alarm)) |-> $past(rd || (sleep && !sleep_q)));

   // R6: arming only flips together with a clear
   assert_arm_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (intr && $past(intr) && !$stable(arm_hi)) |-> $fell(alarm));

   // R7: comparator mode ignores shutdown entry
   assert_cmp_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!intr && $past(!intr) && !$past(fire)) |-> $stable(alarm));

endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
   import thermo_pkg::*;
#(
   parameter int TEMP_W    = 9,
   parameter int REG_W     = 16,
   parameter int QUEUE_MAX = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [TEMP_W-1:0] smp_temp,
   input  logic [REG_W-1:0]  thr_hi,
   input  logic [REG_W-1:0]  thr_lo,
   input  logic [1:0]        cfg_queue,
   input  logic              cfg_pol,
   input  logic              cfg_intr,
   input  logic              cfg_sleep,
   input  logic              reg_rd,
   output logic              alarm_pin
);

   localparam int CNT_W = $clog2(QUEUE_MAX + 1);

   initial begin
      assert (QUEUE_MAX == int'(fault_need(2'd3))) else $fatal(1, "queue depth mismatch");
   end

   logic             above_hi;
   logic             below_lo;
   logic             hit;
   logic             fire;
   logic             alarm;
   logic             hold;
   watch_e           watch;
   logic [CNT_W-1:0] need;

   assign need = CNT_W'(fault_need(cfg_queue));
   assign hit  = (watch == WATCH_HIGH) ? above_hi : below_lo;

   thermo_cmp #(.TEMP_W(TEMP_W), .REG_W(REG_W)) u_cmp (
      .smp      (smp_temp),
      .hi_reg   (thr_hi),
      .lo_reg   (thr_lo),
      .above_hi (above_hi),
      .below_lo (below_lo)
   );

   thermo_fq #(.CNT_W(CNT_W)) u_fq (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (smp_vld),
      .hit   (hit),
      .hold  (hold),
      .need  (need),
      .fire  (fire)
   );

   thermo_state u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .intr  (cfg_intr),
      .sleep (cfg_sleep),
      .rd    (reg_rd),
      .fire  (fire),
      .alarm (alarm),
      .hold  (hold),
      .watch (watch)
   );

   assign alarm_pin = cfg_pol ? alarm : !alarm;

endmodule

// File: tb/tb_thermo_alarm.sv
module tb_thermo_alarm;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [8:0]  smp_temp = '0;
   logic [15:0] thr_hi = 16'h5000;
   logic [15:0] thr_lo = 16'h4B00;
   logic [1:0]  cfg_queue = 2'd0;
   logic        cfg_pol = 1'b0;
   logic        cfg_intr = 1'b0;
   logic        cfg_sleep = 1'b0;
   logic        reg_rd = 1'b0;
   logic        alarm_pin;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   string cur_req = "R8";

   // model state
   bit m_alarm, m_armhi, m_sleep_q;
   int m_cnt;

   thermo_alarm dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .cfg_queue(cfg_queue), .cfg_pol(cfg_pol),
      .cfg_intr(cfg_intr), .cfg_sleep(cfg_sleep), .reg_rd(reg_rd), .alarm_pin(alarm_pin)
   );

   always #10 clk = !clk;

   function automatic int needed(input logic [1:0] q);
      case (q)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 4;
         default: return 6;
      endcase
   endfunction

   // reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_alarm = 0; m_armhi = 1; m_sleep_q = 0; m_cnt = 0;
      end else begin
         int s, hi, lo;
         bit cond;
         s  = $signed(smp_temp);
         hi = $signed(thr_hi[15:7]);
         lo = $signed(thr_lo[15:7]);
         if (cfg_intr) begin
            if (m_alarm) begin
               m_cnt = 0;
               if (reg_rd || (cfg_sleep && !m_sleep_q)) begin
                  m_alarm = 0; m_armhi = !m_armhi;
               end
            end else if (smp_vld) begin
               cond = m_armhi ? (s > hi) : (s < lo);
               if (!cond) m_cnt = 0;
               else if (m_cnt + 1 >= needed(cfg_queue)) begin m_alarm = 1; m_cnt = 0; end
               else m_cnt++;
            end
         end else if (smp_vld) begin
            cond = m_alarm ? (s < lo) : (s > hi);
            if (!cond) m_cnt = 0;
            else if (m_cnt + 1 >= needed(cfg_queue)) begin m_alarm = !m_alarm; m_cnt = 0; end
            else m_cnt++;
         end
         m_sleep_q = cfg_sleep;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit exp;
         exp = cfg_pol ? m_alarm : !m_alarm;
         n_chk++;
         if (alarm_pin !== exp) begin
            n_fail++;
            $display("FAIL %s model: pin=%b expected=%b t=%0t", cur_req, alarm_pin, exp, $time);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
         $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk); #2;
      rst_n = 0; smp_vld = 0; reg_rd = 0; cfg_sleep = 0;
      repeat (2) @(negedge clk);
      #2 rst_n = 1;
   endtask

   task automatic smp(input logic [8:0] d);
      @(negedge clk); #2;
      reg_rd = 0; smp_vld = 1; smp_temp = d;
   endtask

   task automatic smp_n(input logic [8:0] d, input int n);
      for (int i = 0; i < n; i++) smp(d);
   endtask

   // check the pin level explicitly (1 = alarm active)
   task automatic expect_active(input bit act, input string tag);
      bit exp;
      @(negedge clk); #1;
      exp = cfg_pol ? act : !act;
      n_chk++;
      if (alarm_pin !== exp) begin
         n_fail++;
         $display("FAIL %s: pin=%b expected=%b t=%0t", tag, alarm_pin, exp, $time);
      end
      smp_vld = 0; reg_rd = 0;
   endtask

   task automatic rd_pulse();
      @(negedge clk); #2; smp_vld = 0; reg_rd = 1;
      @(negedge clk); #2; reg_rd = 0;
   endtask

   localparam logic [8:0] HOT = 9'd170, COLD = 9'd140, EQ_HI = 9'd160, EQ_LO = 9'd150;

   initial begin
      do_reset();
      cur_req = "R8";
      expect_active(0, "R8 reset inactive, pin high");

      // R1/R2/R3: every queue code in comparator mode
      for (int q = 0; q < 4; q++) begin
         do_reset();
         cfg_queue = q[1:0];
         cur_req = "R1";
         if (needed(q[1:0]) > 1) begin
            smp_n(HOT, needed(q[1:0]) - 1);
            expect_active(0, "R1 one short of queue");
         end
         smp(HOT);
         expect_active(1, "R2 comparator asserts at queue count");
         cur_req = "R3";
         if (needed(q[1:0]) > 1) begin
            smp_n(COLD, needed(q[1:0]) - 1);
            expect_active(1, "R3 one short of release");
         end
         smp(COLD);
         expect_active(0, "R3 comparator releases at queue count");
      end

      // R4: equal samples break a run, queue = 4
      do_reset();
      cfg_queue = 2'd2; cur_req = "R4";
      smp_n(HOT, 3); smp(EQ_HI); smp_n(HOT, 3);
      expect_active(0, "R4 equal-to-upper restarts run");
      smp(HOT);
      expect_active(1, "R4 fresh run of four asserts");
      smp_n(COLD, 3); smp(EQ_LO); smp_n(COLD, 3);
      expect_active(1, "R4 equal-to-lower restarts run");
      smp(COLD);
      expect_active(0, "R4 fresh release run");

      // R10: data without strobe
      cfg_queue = 2'd0; cur_req = "R10";
      @(negedge clk); #2; smp_vld = 0; smp_temp = HOT;
      repeat (5) @(negedge clk);
      expect_active(0, "R10 unstrobed data ignored");

      // R9: low threshold bits ignored, negative thresholds
      do_reset();
      cur_req = "R9";
      thr_hi = 16'h507F;
      smp(EQ_HI);
      expect_active(0, "R9 low bits do not lower threshold");
      smp(9'd161);
      expect_active(1, "R9 above upper field");
      thr_hi = 16'hFF80; thr_lo = 16'hFE7F;
      do_reset();
      smp(9'h1FE);
      expect_active(0, "R9 -1.0 not above -0.5");
      smp(9'd0);
      expect_active(1, "R9 zero above negative threshold");
      smp(9'h1FD);
      expect_active(1, "R9 -1.5 not below -2.0");
      smp(9'h1FB);
      expect_active(0, "R9 -2.5 below -2.0");
      thr_hi = 16'h5000; thr_lo = 16'h4B00;

      // R5/R6: interrupt mode cycle
      do_reset();
      cfg_intr = 1; cfg_queue = 2'd1; cur_req = "R5";
      smp_n(HOT, 2);
      expect_active(1, "R5 interrupt asserts on high event");
      smp_n(COLD, 4);
      expect_active(1, "R5 latched through cold samples");
      cur_req = "R6";
      rd_pulse();
      expect_active(0, "R6 read clears");
      smp_n(HOT, 4);
      expect_active(0, "R6 hot ignored when armed low");
      smp(COLD); smp(EQ_LO); smp(COLD);
      expect_active(0, "R6 low run broken by equal");
      smp(COLD);
      expect_active(1, "R6 low event asserts");
      @(negedge clk); #2; cfg_sleep = 1;
      expect_active(0, "R6 shutdown entry clears");
      cur_req = "R7";
      smp_n(HOT, 2);
      expect_active(1, "R7 samples evaluated while asleep, high re-armed");
      @(negedge clk); #2; cfg_sleep = 0;
      rd_pulse();
      expect_active(0, "R6 second read clears");

      // R7: comparator holds through shutdown
      do_reset();
      cfg_intr = 0; cfg_queue = 2'd0; cur_req = "R7";
      smp(HOT);
      expect_active(1, "R7 comparator active");
      @(negedge clk); #2; cfg_sleep = 1;
      repeat (3) @(negedge clk);
      expect_active(1, "R7 comparator unchanged by shutdown");
      rd_pulse();
      expect_active(1, "R7 comparator unchanged by read");
      cfg_sleep = 0;

      // R8: active-high polarity
      do_reset();
      cfg_pol = 1; cur_req = "R8";
      expect_active(0, "R8 pol1 inactive low");
      smp(HOT);
      expect_active(1, "R8 pol1 active high");
      @(negedge clk); #2; cfg_pol = 0;
      expect_active(1, "R8 pol0 active low");

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule